// File: doc/BRIEF.md
# Bus-Aware Reset Controller with Configuration Latch

This block turns an active-low external reset request into the internal reset for the rest of the chip. It first brings the request into the system clock domain, and only then decides when the reset takes effect. A normal request waits for a bus-cycle boundary, so that a write already under way on the bus can finish. A request marked catastrophic takes effect on the next clock edge. Once the internal reset is asserted, it aborts whatever the chip is doing and stays asserted until the external request has been gone for a fixed number of cycles.

While the internal reset is asserted, the block copies power-up configuration into its own registers on every clock edge. One selected data-bus bit chooses whether all port F pins start as interrupt-request inputs (0xFF) or as general-purpose I/O (0x00). A clock-mode pin gives the clock-source select, and a breakpoint pin gives the breakpoint handling mode. All three values freeze on the edge where the internal reset is released.

The rest of the chip sees the bus only as two inputs: a busy level and an end-of-cycle strobe.

Top module: `bus_reset_ctrl`

## Requirements
- R1: `ext_rst_n` and `cat_req` each pass through a two-flop synchronizer. With the bus idle (`bus_busy`=0), if `ext_rst_n` goes low before rising edge E0, `core_rst` is still low after E1 and is high after E2.
- R2: If `cat_req` is high together with the request, the reset takes effect on the first edge at which both synchronized signals are seen, whatever `bus_busy` and `bus_end` are doing. This is the same timing as R1.
- R3: A request that arrives while `bus_busy`=1, with `cat_req` low, is held pending and `core_rst` stays low. `core_rst` goes high after the first rising edge at which `bus_end`=1.
- R4: A pending request is upgraded when the synchronized `cat_req` becomes high. If `cat_req` rises before edge C0, `core_rst` is high after edge C2 even though no `bus_end` has come.
- R5: Once a request is pending it is committed. If `ext_rst_n` returns high before the bus cycle ends, the reset still takes effect at `bus_end`. The hold count of R6 then starts on the next edge.
- R6: `core_rst` is released only after 16 consecutive edges, taken while it is asserted, at which the synchronized request is inactive. When `ext_rst_n` rises before edge E0 and stays high, `core_rst` is high after E16 and low after E17.
- R7: If the request becomes active again during the hold count, the count restarts from zero. Release then follows the last rise of `ext_rst_n` as in R6.
- R8: On every edge at which `core_rst` is high, `pf_assign` is loaded with 0xFF if `data_bus[9]`=1 and with 0x00 if `data_bus[9]`=0.
- R9: On every edge at which `core_rst` is high, `clk_src_sel` takes the level of `clk_mode_pin` and `bkpt_mode` takes the level of `bkpt_pin`.
- R10: While `core_rst` is low, changes on `data_bus`, `clk_mode_pin` and `bkpt_pin` are ignored. The three configuration outputs keep the values they held at release.
- R11: `por_n`=0 asynchronously forces `core_rst` high and clears `pf_assign`, `clk_src_sel` and `bkpt_mode` to 0. After `por_n` rises before E0, `core_rst` follows the release timing of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset of the controller itself, asynchronous, active low |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous |
| cat_req | input | 1 | Marks the reset request as catastrophic (take effect immediately) |
| bus_busy | input | 1 | High while a bus cycle is in progress |
| bus_end | input | 1 | Strobe, high in the last clock of a bus cycle |
| data_bus | input | 16 | Data bus, sampled for configuration during reset |
| clk_mode_pin | input | 1 | Clock-mode strap pin |
| bkpt_pin | input | 1 | Breakpoint strap pin |
| core_rst | output | 1 | Internal reset to the chip, active high |
| pf_assign | output | 8 | Initial port F pin-assignment value |
| clk_src_sel | output | 1 | Latched clock-source select |
| bkpt_mode | output | 1 | Latched breakpoint-handling mode |

## Verification
The bench holds a bus cycle open and checks that `core_rst` stays low until the `bus_end` edge. A design that ignored the boundary would cut a write short. A design that waited for a strobe on an idle bus would never reset at all. It raises `cat_req` in the middle of a pending wait, and it withdraws the request before the cycle ends. The first shows whether the upgrade happens. The second catches a controller that drops a committed request. It re-asserts the request partway through the hold window and measures the release edge exactly, which catches counts that are off by one or that do not restart. It changes the data bus and strap pins after release, which catches a latch that keeps sampling.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PEND  = 2'd1,
    ST_RESET = 2'd2
  } brc_state_e;

  // Index positions inside the synchronized request vector
  localparam int unsigned REQ_IDX = 0;
  localparam int unsigned CAT_IDX = 1;
  localparam int unsigned REQ_W   = 2;

endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= d;
      end
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/brc_arbiter.sv
module brc_arbiter
  import brc_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic cat_s,
  input  logic bus_busy,
  input  logic bus_end,
  output logic core_rst,
  output logic pend
);

  localparam int unsigned CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);

  // A normal request may go ahead when the bus is idle or the cycle ends now
  function automatic logic boundary_ok(input logic busy, input logic last);
    return !busy || last;
  endfunction

  // True on the last edge of the hold window
  function automatic logic hold_done(input logic [CW-1:0] cnt);
    return cnt == CW'(HOLD_CYCLES - 1);
  endfunction

  brc_state_e     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           rst_q;
  logic           go_now;

  assign go_now = cat_s || boundary_ok(bus_busy, bus_end);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_RUN: begin
        if (req_s) begin
          st_d  = go_now ? ST_RESET : ST_PEND;
          cnt_d = '0;
        end
      end
      ST_PEND: begin
        if (go_now) begin
          st_d  = ST_RESET;
          cnt_d = '0;
        end
      end
      ST_RESET: begin
        if (req_s) begin
          cnt_d = '0;
        end else if (hold_done(cnt_q)) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        st_d  = ST_RESET;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RESET;
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rst_q <= (st_d == ST_RESET);
    end
  end

  assign core_rst = rst_q;
  assign pend     = (st_q == ST_PEND);

endmodule

// File: rtl/brc_cfg_latch.sv
module brc_cfg_latch #(
  parameter int unsigned PF_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            irq_sel_bit,
  input  logic            clk_mode_pin,
  input  logic            bkpt_pin,
  output logic [PF_W-1:0] pf_assign,
  output logic            clk_src_sel,
  output logic            bkpt_mode
);

  // Every port F pin takes the same role from the one strap bit
  function automatic logic [PF_W-1:0] pf_pattern(input logic irq_sel);
    return {PF_W{irq_sel}};
  endfunction

  logic [PF_W-1:0] pf_q;
  logic            cs_q, bk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= '0;
      cs_q <= 1'b0;
      bk_q <= 1'b0;
    end else if (capture) begin
      pf_q <= pf_pattern(irq_sel_bit);
      cs_q <= clk_mode_pin;
      bk_q <= bkpt_pin;
    end
  end

  assign pf_assign   = pf_q;
  assign clk_src_sel = cs_q;
  assign bkpt_mode   = bk_q;

endmodule

// File: rtl/bus_reset_ctrl.sv
module bus_reset_ctrl
  import brc_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PF_W        = 8,
  parameter int unsigned IRQ_SEL_BIT = 9,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              cat_req,
  input  logic              bus_busy,
  input  logic              bus_end,
  input  logic [DATA_W-1:0] data_bus,
  input  logic              clk_mode_pin,
  input  logic              bkpt_pin,
  output logic              core_rst,
  output logic [PF_W-1:0]   pf_assign,
  output logic              clk_src_sel,
  output logic              bkpt_mode
);

  logic [REQ_W-1:0] req_raw, req_sync;
  logic             req_s, cat_s, pend;
  logic             unused_bus;

  assign req_raw[REQ_IDX] = ~ext_rst_n;
  assign req_raw[CAT_IDX] = cat_req;

  // After power-on the request reads as active, so the chip starts in reset
  brc_sync #(
    .W       (REQ_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (REQ_W'(1) << REQ_IDX)
  ) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (req_raw),
    .q     (req_sync)
  );

  assign req_s = req_sync[REQ_IDX];
  assign cat_s = req_sync[CAT_IDX];

  brc_arbiter #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_arb (
    .clk      (clk),
    .rst_n    (por_n),
    .req_s    (req_s),
    .cat_s    (cat_s),
    .bus_busy (bus_busy),
    .bus_end  (bus_end),
    .core_rst (core_rst),
    .pend     (pend)
  );

  brc_cfg_latch #(
    .PF_W (PF_W)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (por_n),
    .capture      (core_rst),
    .irq_sel_bit  (data_bus[IRQ_SEL_BIT]),
    .clk_mode_pin (clk_mode_pin),
    .bkpt_pin     (bkpt_pin),
    .pf_assign    (pf_assign),
    .clk_src_sel  (clk_src_sel),
    .bkpt_mode    (bkpt_mode)
  );

  assign unused_bus = ^data_bus;

endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int unsigned PF_W        = 8,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic            clk,
  input logic            por_n,
  input logic            req_s,
  input logic            cat_s,
  input logic            pend,
  input logic            bus_busy,
  input logic            bus_end,
  input logic            core_rst,
  input logic            irq_bit,
  input logic            clk_mode_pin,
  input logic            bkpt_pin,
  input logic [PF_W-1:0] pf_assign,
  input logic            clk_src_sel,
  input logic            bkpt_mode
);

  localparam int unsigned HW = $clog2(HOLD_CYCLES + 2);

  logic [HW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  quiet_cnt <= '0;
    else if (core_rst && !req_s) quiet_cnt <= quiet_cnt + HW'(1);
    else                         quiet_cnt <= '0;
  end

  AST_IDLE_TAKES: assert property (@(posedge clk) disable iff (!por_n)
    (!core_rst && req_s && !bus_busy) |=> core_rst); // R1

  AST_CAT_TAKES: assert property (@(posedge clk) disable iff (!por_n)
    (!core_rst && req_s && cat_s) |=> core_rst); // R2

  AST_BUSY_DEFERS: assert property (@(posedge clk) disable iff (!por_n)
    (!core_rst && (req_s || pend) && bus_busy && !bus_end && !cat_s) |=> !core_rst); // R3

  AST_END_TAKES: assert property (@(posedge clk) disable iff (!por_n)
    (!core_rst && pend && bus_end) |=> core_rst); // R3

  AST_UPGRADE: assert property (@(posedge clk) disable iff (!por_n)
    (pend && cat_s) |=> core_rst); // R4

  AST_COMMITTED: assert property (@(posedge clk) disable iff (!por_n)
    (pend && !core_rst) |=> (pend || core_rst)); // R5

  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst) |-> (quiet_cnt == HW'(HOLD_CYCLES))); // R6

  AST_REQ_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst && req_s) |=> core_rst); // R7

  AST_PF_CAPTURE: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> (pf_assign == {PF_W{$past(irq_bit)}})); // R8

  AST_PIN_CAPTURE: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> (clk_src_sel == $past(clk_mode_pin) && bkpt_mode == $past(bkpt_pin))); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    !core_rst |=> ($stable(pf_assign) && $stable(clk_src_sel) && $stable(bkpt_mode))); // R10

endmodule

bind bus_reset_ctrl brc_checker #(
  .PF_W        (PF_W),
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .req_s        (req_s),
  .cat_s        (cat_s),
  .pend         (pend),
  .bus_busy     (bus_busy),
  .bus_end      (bus_end),
  .core_rst     (core_rst),
  .irq_bit      (data_bus[IRQ_SEL_BIT]),
  .clk_mode_pin (clk_mode_pin),
  .bkpt_pin     (bkpt_pin),
  .pf_assign    (pf_assign),
  .clk_src_sel  (clk_src_sel),
  .bkpt_mode    (bkpt_mode)
);

// File: tb/tb_bus_reset_ctrl.sv
`timescale 1ns/1ps
module tb_bus_reset_ctrl;

  // Timing restated from the requirements
  localparam int SYNC    = 2;
  localparam int HOLD    = 16;
  localparam int TAKE    = SYNC + 1;   // edges from request to core_rst high
  localparam int RELEASE = SYNC + HOLD; // edges from ext_rst_n rise to core_rst low

  logic        clk = 1'b0;
  logic        por_n, ext_rst_n, cat_req, bus_busy, bus_end;
  logic [15:0] data_bus;
  logic        clk_mode_pin, bkpt_pin;
  logic        core_rst;
  logic [7:0]  pf_assign;
  logic        clk_src_sel, bkpt_mode;

  always #2 clk = ~clk;

  bus_reset_ctrl dut (
    .clk          (clk),
    .por_n        (por_n),
    .ext_rst_n    (ext_rst_n),
    .cat_req      (cat_req),
    .bus_busy     (bus_busy),
    .bus_end      (bus_end),
    .data_bus     (data_bus),
    .clk_mode_pin (clk_mode_pin),
    .bkpt_pin     (bkpt_pin),
    .core_rst     (core_rst),
    .pf_assign    (pf_assign),
    .clk_src_sel  (clk_src_sel),
    .bkpt_mode    (bkpt_mode)
  );

  typedef struct {
    int         cyc;
    bit         is_cfg;
    bit         rst;
    logic [7:0] pf;
    bit         cs;
    bit         bk;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic exp_rst(input int at, input bit v, input string tag);
    exp_t e;
    e.cyc = at; e.is_cfg = 1'b0; e.rst = v; e.pf = '0; e.cs = 1'b0; e.bk = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_cfg(input int at, input logic [7:0] pf, input bit cs, input bit bk,
                         input string tag);
    exp_t e;
    e.cyc = at; e.is_cfg = 1'b1; e.rst = 1'b0; e.pf = pf; e.cs = cs; e.bk = bk; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic direct_chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Monitor: compare every expected item that falls due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        n_checks++;
        if (!q[i].is_cfg) begin
          if (core_rst !== q[i].rst) begin
            n_errors++;
            $display("FAIL %s cyc %0d: core_rst actual %b expected %b",
                     q[i].tag, cyc, core_rst, q[i].rst);
          end
        end else begin
          if (pf_assign !== q[i].pf || clk_src_sel !== q[i].cs || bkpt_mode !== q[i].bk) begin
            n_errors++;
            $display("FAIL %s cyc %0d: cfg actual %h/%b/%b expected %h/%b/%b", q[i].tag, cyc,
                     pf_assign, clk_src_sel, bkpt_mode, q[i].pf, q[i].cs, q[i].bk);
          end
        end
        q.delete(i);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, m;
    por_n = 1'b1; ext_rst_n = 1'b1; cat_req = 1'b0; bus_busy = 1'b0; bus_end = 1'b0;
    data_bus = 16'h0200; clk_mode_pin = 1'b1; bkpt_pin = 1'b0;
    #1 por_n = 1'b0;
    #4;
    // R11: power-on state
    direct_chk(core_rst === 1'b1, "R11 por core_rst", int'(core_rst), 1);
    direct_chk(pf_assign === 8'h00 && clk_src_sel === 1'b0 && bkpt_mode === 1'b0,
               "R11 por cfg", int'(pf_assign), 0);
    tick(3);
    n = cyc; por_n = 1'b1;
    exp_rst(n + RELEASE - 1, 1'b1, "R11 hold after por");
    exp_rst(n + RELEASE, 1'b0, "R6 release after por");
    exp_cfg(n + RELEASE, 8'hFF, 1'b1, 1'b0, "R8 bit9 high gives FF");
    tick(RELEASE + 3);

    // R10: straps change after release, outputs must not move
    data_bus = 16'h0000; clk_mode_pin = 1'b0; bkpt_pin = 1'b1;
    n = cyc;
    exp_cfg(n + 4, 8'hFF, 1'b1, 1'b0, "R10 frozen cfg");
    exp_rst(n + 4, 1'b0, "R10 no reset");
    tick(6);

    // R1: idle bus, new straps captured
    n = cyc; ext_rst_n = 1'b0;
    exp_rst(n + TAKE - 1, 1'b0, "R1 not yet");
    exp_rst(n + TAKE, 1'b1, "R1 taken");
    tick(6);
    m = cyc; ext_rst_n = 1'b1;
    exp_rst(m + RELEASE - 1, 1'b1, "R6 still held");
    exp_rst(m + RELEASE, 1'b0, "R6 released");
    exp_cfg(m + RELEASE, 8'h00, 1'b0, 1'b1, "R8 R9 low bit9 and pins");
    tick(RELEASE + 4);
    data_bus = 16'h0200; clk_mode_pin = 1'b1; bkpt_pin = 1'b0;

    // R3: busy bus defers until bus_end
    bus_busy = 1'b1;
    n = cyc; ext_rst_n = 1'b0;
    exp_rst(n + 4, 1'b0, "R3 deferred");
    exp_rst(n + 6, 1'b0, "R3 still deferred");
    tick(6);
    bus_end = 1'b1;
    exp_rst(n + 7, 1'b1, "R3 taken at bus_end");
    tick(1);
    bus_end = 1'b0; bus_busy = 1'b0;
    m = cyc; ext_rst_n = 1'b1;
    exp_rst(m + RELEASE, 1'b0, "R6 release after R3");
    tick(RELEASE + 4);

    // R2: catastrophic ignores the busy bus
    bus_busy = 1'b1; cat_req = 1'b1;
    n = cyc; ext_rst_n = 1'b0;
    exp_rst(n + TAKE - 1, 1'b0, "R2 not yet");
    exp_rst(n + TAKE, 1'b1, "R2 immediate");
    tick(4);
    cat_req = 1'b0; bus_busy = 1'b0;
    m = cyc; ext_rst_n = 1'b1;
    exp_rst(m + RELEASE, 1'b0, "R6 release after R2");
    tick(RELEASE + 4);

    // R4: pending request upgraded by cat_req
    bus_busy = 1'b1;
    n = cyc; ext_rst_n = 1'b0;
    tick(5);
    cat_req = 1'b1;
    exp_rst(n + 5 + SYNC, 1'b0, "R4 still pending");
    exp_rst(n + 5 + TAKE, 1'b1, "R4 upgraded");
    tick(4);
    cat_req = 1'b0; bus_busy = 1'b0;
    m = cyc; ext_rst_n = 1'b1;
    exp_rst(m + RELEASE, 1'b0, "R6 release after R4");
    tick(RELEASE + 4);

    // R5: request withdrawn while pending still completes
    bus_busy = 1'b1;
    n = cyc; ext_rst_n = 1'b0;
    tick(4);
    ext_rst_n = 1'b1;
    exp_rst(n + 8, 1'b0, "R5 pending");
    tick(4);
    bus_end = 1'b1;
    exp_rst(n + 9, 1'b1, "R5 committed");
    exp_rst(n + 9 + HOLD - 1, 1'b1, "R5 hold");
    exp_rst(n + 9 + HOLD, 1'b0, "R5 hold end");
    tick(1);
    bus_end = 1'b0; bus_busy = 1'b0;
    tick(HOLD + 4);

    // R7: re-assertion during hold restarts the count
    n = cyc; ext_rst_n = 1'b0;
    tick(6);
    m = cyc; ext_rst_n = 1'b1;
    tick(8);
    ext_rst_n = 1'b0;
    tick(2);
    ext_rst_n = 1'b1;
    exp_rst(m + RELEASE + 2, 1'b1, "R7 restarted");
    exp_rst(m + 10 + RELEASE - 1, 1'b1, "R7 held");
    exp_rst(m + 10 + RELEASE, 1'b0, "R7 released");
    tick(RELEASE + 4);

    // R11: power-on reset mid-run
    tick(3);
    por_n = 1'b0;
    #1;
    direct_chk(core_rst === 1'b1, "R11 async core_rst", int'(core_rst), 1);
    direct_chk(pf_assign === 8'h00 && clk_src_sel === 1'b0 && bkpt_mode === 1'b0,
               "R11 async cfg", int'(pf_assign), 0);
    tick(2);
    n = cyc; por_n = 1'b1;
    exp_rst(n + RELEASE - 1, 1'b1, "R11 hold");
    exp_rst(n + RELEASE, 1'b0, "R11 release");
    exp_cfg(n + RELEASE, 8'hFF, 1'b1, 1'b0, "R8 R9 recapture");
    tick(RELEASE + 4);

    while (q.size() > 0) begin
      n_checks++;
      n_errors++;
      $display("FAIL %s: actual unchecked expected cycle %0d", q[0].tag, q[0].cyc);
      void'(q.pop_front());
    end
    finish_run();
  end

endmodule